// File: doc/BRIEF.md
# Floating-Point Exception Status and Trap Unit

This block holds the exception portion of a floating-point status/control register and decides when a completed floating-point instruction must trap. On each instruction-complete strobe it receives five exception indications from the arithmetic datapath, the class of the instruction and a per-operand flag marking quiet-NaN or infinity sources. From these it derives the exceptions the instruction really reports, rewrites the per-instruction cause field and ORs the same bits into the sticky flag field.

When any reported exception has its enable bit set, the block issues a one-cycle trap request with a 5-bit trap code and raises a halt to the floating-point pipeline. The halt stays up until the CPU acknowledges it. While halted, further completion strobes are ignored. Software reads and writes the whole register through a simple port. A write has priority over a hardware update in the same cycle, but flag bits set by hardware in that cycle are still merged in.

Top module: `fpu_exc_unit`

## Requirements
- R1: The register reads as {mode[15], enable[14:10], cause[9:5], flags[4:0]}. Inside each 5-bit field, bit 4 is invalid (V), bit 3 divide-by-zero (Z), bit 2 overflow (O), bit 1 underflow (U) and bit 0 inexact (I). After reset the register, `halt`, `trap_req` and `trap_code` are all 0.
- R2: Each accepted completion strobe overwrites the cause field with that instruction's reported exceptions, including when there are none.
- R3: Reported exceptions are ORed into the flag field. A flag bit is cleared only by a software write of 0.
- R4: `trap_req` is high for exactly the one cycle after an accepted strobe whose reported exceptions AND the enable field is nonzero. `trap_code` then equals that AND.
- R5: A reported exception whose enable bit is 0 raises no trap, but it still sets its cause and flag bits.
- R6: `halt` rises together with `trap_req` and stays high until `cpu_ack` is pulsed. While `halt` is high, completion strobes change nothing.
- R7: When the mode bit and enable V are both 1, a quiet-NaN/infinity flag on any source operand of an exception-capable class reports V. In every other case that flag has no effect.
- R8: Instruction classes (`op_class`) limit what may be reported: 1 add, 2 sub, 3 mul, 5 mul-acc and 10 double-to-single allow V,O,U,I; 4 divide allows all five; 6 and 7 compares, 9 truncate and 11 single-to-double allow V only; 8 int-to-float allows I only; 12 square root allows V,I; every other code reports nothing.
- R9: A software write in the same cycle as an accepted strobe loads the written fields. The flags become the written flags ORed with that instruction's reported bits.
- R10: A software write loads all four fields exactly as written and never produces a trap by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| done | input | 1 | Instruction-complete strobe |
| op_class | input | 4 | Class of the completing instruction |
| exc_in | input | 5 | Raw exception indications, V..I at bits 4..0 |
| src_special | input | NSRC (3) | Per source operand: quiet NaN or infinity |
| sw_we | input | 1 | Software write enable |
| sw_wdata | input | 16 | Software write data |
| sw_rdata | output | 16 | Current register contents |
| cpu_ack | input | 1 | CPU acknowledge, clears halt |
| trap_req | output | 1 | One-cycle trap request |
| trap_code | output | 5 | Enabled exceptions that caused the trap |
| halt | output | 1 | Floating-point pipeline halt |

## Verification
On every cycle the assertions check these properties: a trap request lasts one cycle, always comes with halt and carries only enabled bits. Flags never drop without a write. Halt holds until acknowledged, the register stays frozen while halted, and no trap appears without an accepted strobe. The directed scenarios show the values that need a model of the instruction: cause contents per class, the quiet-NaN/infinity mode gating, the merge of a write with a simultaneous update, and exact readback after writes.

// File: rtl/fpu_exc_pkg.sv
// Shared definitions for the FP exception unit: field width, bit
// positions inside each field and the instruction class codes.
// Assumes the fixed V,Z,O,U,I order from bit 4 down to bit 0.
package fpu_exc_pkg;
    localparam int NEXC  = 5;
    localparam int CLS_W = 4;
    localparam int BIT_V = 4;
    localparam int BIT_Z = 3;
    localparam int BIT_O = 2;
    localparam int BIT_U = 1;
    localparam int BIT_I = 0;

    typedef logic [NEXC-1:0] exc_t;

    typedef enum logic [CLS_W-1:0] {
        CLS_OTHER = 4'd0,
        CLS_ADD   = 4'd1,
        CLS_SUB   = 4'd2,
        CLS_MUL   = 4'd3,
        CLS_DIV   = 4'd4,
        CLS_MAC   = 4'd5,
        CLS_CMPEQ = 4'd6,
        CLS_CMPGT = 4'd7,
        CLS_ITOF  = 4'd8,
        CLS_TRUNC = 4'd9,
        CLS_CVTDS = 4'd10,
        CLS_CVTSD = 4'd11,
        CLS_SQRT  = 4'd12
    } op_cls_e;

    // Exceptions that a class is able to report (R8)
    function automatic exc_t class_mask(input logic [CLS_W-1:0] cls);
        exc_t m;
        case (cls)
            CLS_ADD, CLS_SUB, CLS_MUL, CLS_MAC, CLS_CVTDS: m = 5'b10111;
            CLS_DIV:                                        m = 5'b11111;
            CLS_CMPEQ, CLS_CMPGT, CLS_TRUNC, CLS_CVTSD:     m = 5'b10000;
            CLS_ITOF:                                       m = 5'b00001;
            CLS_SQRT:                                       m = 5'b10001;
            default:                                        m = 5'b00000;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/fpu_exc_detect.sv
// Combinational derivation of the exceptions an instruction reports.
// Adds the quiet-NaN/infinity invalid check when the mode bit and the
// V enable are both set, then limits the result to what the class may
// report. Assumes inputs are only meaningful with a completion strobe.
module fpu_exc_detect
    import fpu_exc_pkg::*;
#(
    parameter int NSRC = 3
) (
    input  logic [CLS_W-1:0] op_class,
    input  exc_t             exc_in,
    input  logic [NSRC-1:0]  src_special,
    input  logic             qis_mode,
    input  logic             en_v,
    output exc_t             eff
);
    exc_t mask;
    exc_t raw;

    // Merge special-operand invalid into the raw set, then apply class mask
    always_comb begin
        mask = class_mask(op_class);
        raw  = exc_in;
        if (qis_mode && en_v && (|src_special))
            raw[BIT_V] = 1'b1;
        eff = raw & mask;
    end
endmodule

// File: rtl/fpu_exc_regs.sv
// Register fields: flags, cause, enable and the special-operand mode bit.
// A software write wins over the hardware update but hardware flag bits
// of the same cycle are ORed into the written flags.
module fpu_exc_regs
    import fpu_exc_pkg::*;
#(
    parameter int REG_W = 3*NEXC + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  exc_t             eff,
    input  logic             sw_we,
    input  logic [REG_W-1:0] sw_wdata,
    output exc_t             flags,
    output exc_t             cause,
    output exc_t             enable,
    output logic             qis_mode,
    output logic [REG_W-1:0] rdata
);
    localparam int OFS_FLG = 0;
    localparam int OFS_CAU = NEXC;
    localparam int OFS_ENA = 2*NEXC;
    localparam int OFS_QIS = 3*NEXC;

    exc_t hw_set;
    assign hw_set = upd ? eff : '0;

    // Field update with write priority and hardware flag merge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags    <= '0;
            cause    <= '0;
            enable   <= '0;
            qis_mode <= 1'b0;
        end else if (sw_we) begin
            flags    <= sw_wdata[OFS_FLG +: NEXC] | hw_set;
            cause    <= sw_wdata[OFS_CAU +: NEXC];
            enable   <= sw_wdata[OFS_ENA +: NEXC];
            qis_mode <= sw_wdata[OFS_QIS];
        end else if (upd) begin
            flags    <= flags | eff;
            cause    <= eff;
        end
    end

    assign rdata = {qis_mode, enable, cause, flags};
endmodule

// File: rtl/fpu_exc_trap.sv
// Trap decision: a one-cycle request with the enabled-exception code and
// a halt that holds until the CPU acknowledges. Assumes upd is already
// blocked while halted, so a second request cannot overlap the first.
module fpu_exc_trap
    import fpu_exc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic upd,
    input  exc_t eff,
    input  exc_t enable,
    input  logic cpu_ack,
    output logic trap_req,
    output exc_t trap_code,
    output logic halt
);
    exc_t hit;
    logic fire;

    assign hit  = eff & enable;
    assign fire = upd && (|hit);

    // Register the request pulse, its code and the halt state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_req  <= 1'b0;
            trap_code <= '0;
            halt      <= 1'b0;
        end else begin
            trap_req  <= fire;
            trap_code <= fire ? hit : '0;
            if (fire)
                halt <= 1'b1;
            else if (cpu_ack)
                halt <= 1'b0;
        end
    end
endmodule

// File: rtl/fpu_exc_unit.sv
// Top of the FP exception status and trap unit. Completion strobes are
// accepted only while the pipeline is not halted; all outputs are
// registered except the register readback.
module fpu_exc_unit
    import fpu_exc_pkg::*;
#(
    parameter int NSRC = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                done,
    input  logic [CLS_W-1:0]    op_class,
    input  logic [NEXC-1:0]     exc_in,
    input  logic [NSRC-1:0]     src_special,
    input  logic                sw_we,
    input  logic [3*NEXC:0]     sw_wdata,
    output logic [3*NEXC:0]     sw_rdata,
    input  logic                cpu_ack,
    output logic                trap_req,
    output logic [NEXC-1:0]     trap_code,
    output logic                halt
);
    localparam int REG_W = 3*NEXC + 1;

    exc_t eff;
    exc_t flags;
    exc_t cause;
    exc_t enable;
    logic qis_mode;
    logic upd;

    assign upd = done && !halt;

    fpu_exc_detect #(.NSRC(NSRC)) u_detect (
        .op_class    (op_class),
        .exc_in      (exc_in),
        .src_special (src_special),
        .qis_mode    (qis_mode),
        .en_v        (enable[BIT_V]),
        .eff         (eff)
    );

    fpu_exc_regs #(.REG_W(REG_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd      (upd),
        .eff      (eff),
        .sw_we    (sw_we),
        .sw_wdata (sw_wdata),
        .flags    (flags),
        .cause    (cause),
        .enable   (enable),
        .qis_mode (qis_mode),
        .rdata    (sw_rdata)
    );

    fpu_exc_trap u_trap (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd       (upd),
        .eff       (eff),
        .enable    (enable),
        .cpu_ack   (cpu_ack),
        .trap_req  (trap_req),
        .trap_code (trap_code),
        .halt      (halt)
    );
endmodule

// File: rtl/fpu_exc_chk.sv
// Port-level checker for fpu_exc_unit, attached with bind below.
// Assumes the register layout {mode, enable, cause, flags}.
module fpu_exc_chk #(
    parameter int NEXC = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            done,
    input logic            halt,
    input logic            sw_we,
    input logic [3*NEXC:0] sw_rdata,
    input logic            cpu_ack,
    input logic            trap_req,
    input logic [NEXC-1:0] trap_code
);
    logic [NEXC-1:0] flg;
    logic [NEXC-1:0] cau;
    logic [NEXC-1:0] ena;
    assign flg = sw_rdata[NEXC-1:0];
    assign cau = sw_rdata[2*NEXC-1:NEXC];
    assign ena = sw_rdata[3*NEXC-1:2*NEXC];

    AST_TRAP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> !trap_req); // R4
    AST_TRAP_CODE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> ((trap_code != '0) && ((trap_code & ~$past(ena)) == '0))); // R4
    AST_NO_TRAP_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && !halt) |=> !trap_req); // R10
    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_we |=> (($past(flg) & ~flg) == '0)); // R3
    AST_CAUSE_IN_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !halt && !sw_we) |=> ((cau & ~flg) == '0)); // R2
    AST_TRAP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> halt); // R6
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !cpu_ack) |=> halt); // R6
    AST_HALT_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !sw_we) |=> $stable(sw_rdata)); // R6
endmodule

bind fpu_exc_unit fpu_exc_chk #(.NEXC(5)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .halt      (halt),
    .sw_we     (sw_we),
    .sw_rdata  (sw_rdata),
    .cpu_ack   (cpu_ack),
    .trap_req  (trap_req),
    .trap_code (trap_code)
);

// File: tb/sim_fpu_exc_unit.sv
// Directed bench for fpu_exc_unit: one task per scenario, inputs driven
// and outputs sampled on the falling edge.
module sim_fpu_exc_unit;
    localparam logic [4:0] VB = 5'h10, ZB = 5'h08, OB = 5'h04, UB = 5'h02, IB = 5'h01;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        done = 1'b0;
    logic [3:0]  op_class = '0;
    logic [4:0]  exc_in = '0;
    logic [2:0]  src_special = '0;
    logic        sw_we = 1'b0;
    logic [15:0] sw_wdata = '0;
    logic [15:0] sw_rdata;
    logic        cpu_ack = 1'b0;
    logic        trap_req;
    logic [4:0]  trap_code;
    logic        halt;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    fpu_exc_unit #(.NSRC(3)) u0 (
        .clk(clk), .rst_n(rst_n), .done(done), .op_class(op_class),
        .exc_in(exc_in), .src_special(src_special), .sw_we(sw_we),
        .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .cpu_ack(cpu_ack),
        .trap_req(trap_req), .trap_code(trap_code), .halt(halt)
    );

    function automatic logic [15:0] regv(input logic q, input logic [4:0] e,
                                         input logic [4:0] c, input logic [4:0] f);
        return {q, e, c, f};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] d);
        sw_we = 1'b1; sw_wdata = d;
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    task automatic issue(input logic [3:0] cls, input logic [4:0] e, input logic [2:0] s);
        done = 1'b1; op_class = cls; exc_in = e; src_special = s;
        @(negedge clk);
        done = 1'b0; exc_in = '0; src_special = '0;
    endtask

    task automatic ack();
        cpu_ack = 1'b1;
        @(negedge clk);
        cpu_ack = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 reset register", sw_rdata, 16'h0);
        check("R1 reset halt", halt, 0);
        check("R1 reset trap_req", trap_req, 0);
        check("R1 reset trap_code", trap_code, 0);
    endtask

    task automatic t_cause_flags();
        wr(16'h0);
        issue(4'd1, OB, 3'b0);
        check("R5 disabled O sets cause+flag", sw_rdata, regv(0, 0, OB, OB));
        check("R5 no trap when disabled", trap_req, 0);
        issue(4'd3, IB, 3'b0);
        check("R2 R3 cause replaced, flags accumulate", sw_rdata, regv(0, 0, IB, OB|IB));
        issue(4'd0, 5'h1F, 3'b0);
        check("R2 R8 other class clears cause", sw_rdata, regv(0, 0, 0, OB|IB));
    endtask

    task automatic t_trap();
        wr(regv(0, ZB, 0, 0));
        issue(4'd4, ZB|IB, 3'b0);
        check("R4 trap_req", trap_req, 1);
        check("R4 trap_code", trap_code, ZB);
        check("R6 halt with trap", halt, 1);
        check("R3 flags on trap", sw_rdata, regv(0, ZB, ZB|IB, ZB|IB));
        @(negedge clk);
        check("R4 trap_req one cycle", trap_req, 0);
        check("R6 halt held", halt, 1);
        issue(4'd1, OB, 3'b0);
        check("R6 strobe ignored while halted", sw_rdata, regv(0, ZB, ZB|IB, ZB|IB));
        check("R6 no trap while halted", trap_req, 0);
        ack();
        check("R6 halt cleared by ack", halt, 0);
    endtask

    task automatic t_mask();
        wr(16'h0);
        issue(4'd6, VB|OB|UB|IB, 3'b0);
        check("R8 compare reports V only", sw_rdata[9:5], VB);
        issue(4'd1, ZB, 3'b0);
        check("R8 add drops Z", sw_rdata[9:5], 0);
        issue(4'd8, VB|IB, 3'b0);
        check("R8 int-to-float reports I only", sw_rdata[9:5], IB);
        issue(4'd12, 5'h1F, 3'b0);
        check("R8 sqrt reports V,I", sw_rdata[9:5], VB|IB);
        issue(4'd4, 5'h1F, 3'b0);
        check("R8 divide reports all", sw_rdata[9:5], 5'h1F);
    endtask

    task automatic t_qis();
        wr(regv(1, VB, 0, 0));
        issue(4'd1, 5'h0, 3'b010);
        check("R7 special operand traps V", trap_req, 1);
        check("R7 trap_code V", trap_code, VB);
        ack();
        wr(regv(0, VB, 0, 0));
        issue(4'd1, 5'h0, 3'b001);
        check("R7 mode off: no V", sw_rdata[9:5], 0);
        check("R7 mode off: no trap", trap_req, 0);
        wr(regv(1, 0, 0, 0));
        issue(4'd2, 5'h0, 3'b100);
        check("R7 V disabled: no V", sw_rdata[9:5], 0);
    endtask

    task automatic t_swprio();
        wr(regv(0, 0, 0, OB|UB));
        sw_we = 1'b1; sw_wdata = regv(0, 0, 0, 0);
        done = 1'b1; op_class = 4'd1; exc_in = IB;
        @(negedge clk);
        sw_we = 1'b0; done = 1'b0; exc_in = '0;
        check("R9 write clears, hw bit merged", sw_rdata, regv(0, 0, 0, IB));
    endtask

    task automatic t_swwrite();
        wr(regv(1, 5'h1F, 5'h0A, 5'h05));
        check("R10 write readback", sw_rdata, regv(1, 5'h1F, 5'h0A, 5'h05));
        check("R10 write no trap", trap_req, 0);
        check("R10 write no halt", halt, 0);
        wr(16'h0);
        check("R3 write of 0 clears flags", sw_rdata, 16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cause_flags();
        t_trap();
        t_mask();
        t_qis();
        t_swprio();
        t_swwrite();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule